// File: doc/BRIEF.md
# DRAM Test Command Sequencer

This block plays back a short programmed list of DRAM commands for memory training and stress testing. It has four command slots. Each slot holds the active-low row strobe, column strobe and write enable, the clock-enable and on-die-termination values for each rank, a chip-select pattern with an optional rank-decode mode, a repetition count, a gap between repeated commands, an idle time after the slot and a data direction. A two-bit field picks the last slot that runs, so a pass runs slot 0 up to that slot.

Passes nest inside an iteration count. Writing a non-zero iteration value starts a run. A pass ends with a programmable wait. The count drops after each pass. The value 0xFF repeats until software clears the field. The data comparator, the PHY and refresh arbitration are outside the block. An error input and an abort input stand in for them. A five-bit status output and a one-cycle trigger report the outcome of each run.

Top module: `dram_test_seq`

## Requirements
- R1: While not busy, a change of `iter_i` from zero to a non-zero value starts a run. The cycle after the edge that sees it is a command cycle for slot 0. A run does not restart while `iter_i` stays non-zero after it ends.
- R2: Slots run in ascending order from 0 to `last_slot_i`. `cmd_valid_o` is high for one cycle per command, and `slot_o` gives the slot in use.
- R3: A slot with repetition count N (1 to 511) issues N commands and a count of 0 issues one. Exactly `gap` cycles without a command separate consecutive repeats.
- R4: After the last command of a slot, `idle` cycles without a command follow before the next slot or the end of the pass.
- R5: After the last slot, `wait_i` cycles without a command follow. The run then repeats until the number of passes equals the starting `iter_i` value, and then ends with DONE set.
- R6: A starting value of 0xFF repeats passes without end. Clearing `iter_i` to zero while busy stops the run at the next edge with DONE set, in any mode.
- R7: With `stop_on_err_i` high, an `err_i` seen while busy halts the run at the next edge and sets ERROR. With it low, the run continues.
- R8: `abort_i` seen while busy halts the run at the next edge and sets PANIC. It takes priority over an error stop and over a clear of the iteration field.
- R9: `trig_o` is a one-cycle pulse in the cycle after the first `err_i` of a run. Later errors of the same run give no pulse.
- R10: On a command cycle, bit r of `cs_n_o` is the slot's programmed chip-select bit. In decode mode, the bit is also forced low when rank select equals r. On other cycles, all chip selects are high, the row, column and write strobes are high, and `dir_o` is 0. The `dir_o` codes are 00 none, 01 read, 10 write and 11 both.
- R11: The `status_o` bits are: bit0 idle, bit1 busy, bit2 done, bit3 error and bit4 panic. Idle is the inverse of busy. Done, error and panic clear when a run starts. After reset the value is 00001.
- R12: While busy, `cke_o` and `odt_o` follow the current slot's values. While not busy, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iter_i | input | 8 | Iteration field, 0xFF repeats without end |
| last_slot_i | input | 2 | Index of last slot in a pass |
| wait_i | input | 9 | Wait cycles after each pass |
| stop_on_err_i | input | 1 | Halt the run on error |
| err_i | input | 1 | Error from the data checker |
| abort_i | input | 1 | External abort (refresh panic) |
| slot_cmd_i | input | 12 | Per slot {we_n, cas_n, ras_n} |
| slot_cke_i | input | 16 | Per slot clock enable per rank |
| slot_odt_i | input | 16 | Per slot termination per rank |
| slot_cs_i | input | 16 | Per slot programmed chip selects (active low) |
| slot_csmode_i | input | 4 | Per slot rank-decode mode |
| slot_rank_i | input | 8 | Per slot rank select |
| slot_reps_i | input | 36 | Per slot repetition count |
| slot_gap_i | input | 20 | Per slot gap between repeats |
| slot_idle_i | input | 36 | Per slot idle after the slot |
| slot_dir_i | input | 8 | Per slot data direction |
| cmd_valid_o | output | 1 | Command issued this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 4 | Clock enable per rank |
| odt_o | output | 4 | On-die termination per rank |
| cs_n_o | output | 4 | Chip select per rank, active low |
| dir_o | output | 2 | Data direction of the command |
| slot_o | output | 2 | Current slot |
| status_o | output | 5 | {panic, error, done, busy, idle} |
| trig_o | output | 1 | First-error trigger pulse |

## Verification
A wrong repetition, gap or idle counter shows up on `cmd_valid_o` or `slot_o` in the first cycle where a command comes early, comes late or is missing. The per-cycle reference comparison catches it in that same cycle. A wrong iteration count or a lost infinite-mode flag shows only at the end of a pass: the run stops a pass too early, or it never sets DONE. Mistakes in the halt priority or in the error-seen flag show in the status and trigger one cycle after the stimulus.

// File: rtl/dts_pkg.sv
package dts_pkg;
    parameter int NSLOT  = 4;
    parameter int SLOT_W = 2;
    parameter int REP_W  = 9;
    parameter int GAP_W  = 5;
    parameter int IDLE_W = 9;
    parameter int WAIT_W = 9;
    parameter int ITER_W = 8;
    parameter int DIR_W  = 2;
    parameter int CMD_W  = 3;
    parameter int CNT_W  = (IDLE_W > WAIT_W) ? IDLE_W : WAIT_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_GAP, ST_POST, ST_WAIT
    } seq_st_e;

    typedef struct packed {
        seq_st_e             st;
        logic [SLOT_W-1:0]   slot;
        logic [REP_W-1:0]    reps;
        logic [CNT_W-1:0]    cnt;
        logic [ITER_W-1:0]   iters;
        logic                iter_zero;
        logic                done;
        logic                err;
        logic                panic;
        logic                seen;
        logic                trig;
    } seq_state_t;
endpackage

// File: rtl/dts_slot_mux.sv
module dts_slot_mux
    import dts_pkg::*;
#(
    parameter int RANKS  = 4,
    parameter int RSEL_W = $clog2(RANKS)
) (
    input  logic [SLOT_W-1:0]       slot_i,
    input  logic [NSLOT*CMD_W-1:0]  cmd_all_i,
    input  logic [NSLOT*RANKS-1:0]  cke_all_i,
    input  logic [NSLOT*RANKS-1:0]  odt_all_i,
    input  logic [NSLOT*RANKS-1:0]  cs_all_i,
    input  logic [NSLOT-1:0]        mode_all_i,
    input  logic [NSLOT*RSEL_W-1:0] rank_all_i,
    input  logic [NSLOT*GAP_W-1:0]  gap_all_i,
    input  logic [NSLOT*IDLE_W-1:0] idle_all_i,
    input  logic [NSLOT*DIR_W-1:0]  dir_all_i,
    output logic [CMD_W-1:0]        cmd_o,
    output logic [RANKS-1:0]        cke_o,
    output logic [RANKS-1:0]        odt_o,
    output logic [RANKS-1:0]        cs_o,
    output logic                    mode_o,
    output logic [RSEL_W-1:0]       rank_o,
    output logic [GAP_W-1:0]        gap_o,
    output logic [IDLE_W-1:0]       idle_o,
    output logic [DIR_W-1:0]        dir_o
);
    always_comb begin
        cmd_o  = cmd_all_i[slot_i*CMD_W +: CMD_W];
        cke_o  = cke_all_i[slot_i*RANKS +: RANKS];
        odt_o  = odt_all_i[slot_i*RANKS +: RANKS];
        cs_o   = cs_all_i[slot_i*RANKS +: RANKS];
        mode_o = mode_all_i[slot_i];
        rank_o = rank_all_i[slot_i*RSEL_W +: RSEL_W];
        gap_o  = gap_all_i[slot_i*GAP_W +: GAP_W];
        idle_o = idle_all_i[slot_i*IDLE_W +: IDLE_W];
        dir_o  = dir_all_i[slot_i*DIR_W +: DIR_W];
    end
endmodule

// File: rtl/dts_cs_decode.sv
module dts_cs_decode #(
    parameter int RANKS  = 4,
    parameter int RSEL_W = $clog2(RANKS)
) (
    input  logic              mode_i,
    input  logic [RSEL_W-1:0] rank_i,
    input  logic [RANKS-1:0]  cs_i,
    output logic [RANKS-1:0]  cs_n_o
);
    for (genvar r = 0; r < RANKS; r++) begin : g_rank
        logic hit;
        assign hit       = (rank_i == RSEL_W'(r));
        assign cs_n_o[r] = mode_i ? (cs_i[r] & ~hit) : cs_i[r];
    end
endmodule

// File: rtl/dts_ctrl.sv
module dts_ctrl
    import dts_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ITER_W-1:0]       iter_i,
    input  logic [SLOT_W-1:0]       last_slot_i,
    input  logic [WAIT_W-1:0]       wait_i,
    input  logic                    stop_on_err_i,
    input  logic                    err_i,
    input  logic                    abort_i,
    input  logic [NSLOT*REP_W-1:0]  reps_all_i,
    input  logic [GAP_W-1:0]        cur_gap_i,
    input  logic [IDLE_W-1:0]       cur_idle_i,
    output seq_st_e                 st_o,
    output logic [SLOT_W-1:0]       slot_o,
    output logic [4:0]              status_o,
    output logic                    trig_o
);
    seq_state_t q, d;
    logic busy_q;

    function automatic logic [REP_W-1:0] eff_reps(input logic [NSLOT*REP_W-1:0] all,
                                                  input logic [SLOT_W-1:0] idx);
        logic [REP_W-1:0] r;
        r = all[idx*REP_W +: REP_W];
        return (r == '0) ? REP_W'(1) : r;
    endfunction

    function automatic seq_state_t go_first(input seq_state_t s, input logic [REP_W-1:0] r0);
        s.st   = ST_CMD;
        s.slot = '0;
        s.reps = r0;
        return s;
    endfunction

    function automatic seq_state_t end_pass(input seq_state_t s, input logic [REP_W-1:0] r0);
        if (s.iters == '1) begin
            s = go_first(s, r0);
        end else if (s.iters == ITER_W'(1)) begin
            s.st   = ST_IDLE;
            s.done = 1'b1;
        end else begin
            s.iters = s.iters - 1'b1;
            s = go_first(s, r0);
        end
        return s;
    endfunction

    function automatic seq_state_t next_slot(input seq_state_t s, input logic [SLOT_W-1:0] last,
                                             input logic [WAIT_W-1:0] wv,
                                             input logic [REP_W-1:0] rn,
                                             input logic [REP_W-1:0] r0);
        if (s.slot == last) begin
            if (wv != '0) begin
                s.st  = ST_WAIT;
                s.cnt = CNT_W'(wv);
            end else begin
                s = end_pass(s, r0);
            end
        end else begin
            s.slot = s.slot + 1'b1;
            s.reps = rn;
            s.st   = ST_CMD;
        end
        return s;
    endfunction

    assign busy_q = (q.st != ST_IDLE);

    always_comb begin
        logic [REP_W-1:0] r0, rn;
        r0 = eff_reps(reps_all_i, '0);
        rn = eff_reps(reps_all_i, q.slot + 1'b1);
        d = q;
        d.trig      = 1'b0;
        d.iter_zero = (iter_i == '0);
        if (!busy_q) begin
            if (iter_i != '0 && q.iter_zero) begin
                d       = go_first(d, r0);
                d.iters = iter_i;
                d.done  = 1'b0;
                d.err   = 1'b0;
                d.panic = 1'b0;
                d.seen  = 1'b0;
            end
        end else begin
            if (err_i && !q.seen) begin
                d.seen = 1'b1;
                d.trig = 1'b1;
            end
            if (abort_i) begin
                d.st    = ST_IDLE;
                d.panic = 1'b1;
            end else if (err_i && stop_on_err_i) begin
                d.st  = ST_IDLE;
                d.err = 1'b1;
            end else if (iter_i == '0) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end else begin
                case (q.st)
                    ST_CMD: begin
                        if (q.reps > REP_W'(1)) begin
                            d.reps = q.reps - 1'b1;
                            if (cur_gap_i != '0) begin
                                d.st  = ST_GAP;
                                d.cnt = CNT_W'(cur_gap_i);
                            end
                        end else if (cur_idle_i != '0) begin
                            d.st  = ST_POST;
                            d.cnt = CNT_W'(cur_idle_i);
                        end else begin
                            d = next_slot(d, last_slot_i, wait_i, rn, r0);
                        end
                    end
                    ST_GAP:  if (q.cnt == CNT_W'(1)) d.st = ST_CMD;
                             else d.cnt = q.cnt - 1'b1;
                    ST_POST: if (q.cnt == CNT_W'(1)) d = next_slot(d, last_slot_i, wait_i, rn, r0);
                             else d.cnt = q.cnt - 1'b1;
                    ST_WAIT: if (q.cnt == CNT_W'(1)) d = end_pass(d, r0);
                             else d.cnt = q.cnt - 1'b1;
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.iter_zero <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign st_o     = q.st;
    assign slot_o   = q.slot;
    assign status_o = {q.panic, q.err, q.done, busy_q, ~busy_q};
    assign trig_o   = q.trig;

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && iter_i != '0 && q.iter_zero) |=> (st_o == ST_CMD && slot_o == '0));
    p_gap_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CMD && q.reps > REP_W'(1) && cur_gap_i != '0 && !abort_i && iter_i != '0
         && !(err_i && stop_on_err_i)) |=> (st_o == ST_GAP));
    p_clear_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && iter_i == '0 && !abort_i && !(err_i && stop_on_err_i))
        |=> (status_o[2] && status_o[0]));
    p_stop_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && err_i && stop_on_err_i && !abort_i) |=> (status_o[3] && status_o[0]));
    p_abort_panic_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && abort_i) |=> (status_o[4] && !status_o[1] && !status_o[3]));
    p_trig_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);
endmodule

// File: rtl/dram_test_seq.sv
module dram_test_seq
    import dts_pkg::*;
#(
    parameter int RANKS  = 4,
    parameter int RSEL_W = $clog2(RANKS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ITER_W-1:0]       iter_i,
    input  logic [SLOT_W-1:0]       last_slot_i,
    input  logic [WAIT_W-1:0]       wait_i,
    input  logic                    stop_on_err_i,
    input  logic                    err_i,
    input  logic                    abort_i,
    input  logic [NSLOT*CMD_W-1:0]  slot_cmd_i,
    input  logic [NSLOT*RANKS-1:0]  slot_cke_i,
    input  logic [NSLOT*RANKS-1:0]  slot_odt_i,
    input  logic [NSLOT*RANKS-1:0]  slot_cs_i,
    input  logic [NSLOT-1:0]        slot_csmode_i,
    input  logic [NSLOT*RSEL_W-1:0] slot_rank_i,
    input  logic [NSLOT*REP_W-1:0]  slot_reps_i,
    input  logic [NSLOT*GAP_W-1:0]  slot_gap_i,
    input  logic [NSLOT*IDLE_W-1:0] slot_idle_i,
    input  logic [NSLOT*DIR_W-1:0]  slot_dir_i,
    output logic                    cmd_valid_o,
    output logic                    ras_n_o,
    output logic                    cas_n_o,
    output logic                    we_n_o,
    output logic [RANKS-1:0]        cke_o,
    output logic [RANKS-1:0]        odt_o,
    output logic [RANKS-1:0]        cs_n_o,
    output logic [DIR_W-1:0]        dir_o,
    output logic [SLOT_W-1:0]       slot_o,
    output logic [4:0]              status_o,
    output logic                    trig_o
);
    seq_st_e             st;
    logic [CMD_W-1:0]    cur_cmd;
    logic [RANKS-1:0]    cur_cke, cur_odt, cur_cs, cs_dec;
    logic                cur_mode;
    logic [RSEL_W-1:0]   cur_rank;
    logic [GAP_W-1:0]    cur_gap;
    logic [IDLE_W-1:0]   cur_idle;
    logic [DIR_W-1:0]    cur_dir;
    logic                is_cmd, is_busy;

    dts_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .iter_i(iter_i), .last_slot_i(last_slot_i),
        .wait_i(wait_i), .stop_on_err_i(stop_on_err_i), .err_i(err_i), .abort_i(abort_i),
        .reps_all_i(slot_reps_i), .cur_gap_i(cur_gap), .cur_idle_i(cur_idle),
        .st_o(st), .slot_o(slot_o), .status_o(status_o), .trig_o(trig_o)
    );

    dts_slot_mux #(.RANKS(RANKS), .RSEL_W(RSEL_W)) u_mux (
        .slot_i(slot_o), .cmd_all_i(slot_cmd_i), .cke_all_i(slot_cke_i),
        .odt_all_i(slot_odt_i), .cs_all_i(slot_cs_i), .mode_all_i(slot_csmode_i),
        .rank_all_i(slot_rank_i), .gap_all_i(slot_gap_i), .idle_all_i(slot_idle_i),
        .dir_all_i(slot_dir_i), .cmd_o(cur_cmd), .cke_o(cur_cke), .odt_o(cur_odt),
        .cs_o(cur_cs), .mode_o(cur_mode), .rank_o(cur_rank), .gap_o(cur_gap),
        .idle_o(cur_idle), .dir_o(cur_dir)
    );

    dts_cs_decode #(.RANKS(RANKS), .RSEL_W(RSEL_W)) u_cs (
        .mode_i(cur_mode), .rank_i(cur_rank), .cs_i(cur_cs), .cs_n_o(cs_dec)
    );

    assign is_cmd      = (st == ST_CMD);
    assign is_busy     = (st != ST_IDLE);
    assign cmd_valid_o = is_cmd;
    assign ras_n_o     = is_cmd ? cur_cmd[0] : 1'b1;
    assign cas_n_o     = is_cmd ? cur_cmd[1] : 1'b1;
    assign we_n_o      = is_cmd ? cur_cmd[2] : 1'b1;
    assign cs_n_o      = is_cmd ? cs_dec : '1;
    assign dir_o       = is_cmd ? cur_dir : '0;
    assign cke_o       = is_busy ? cur_cke : '0;
    assign odt_o       = is_busy ? cur_odt : '0;
endmodule

// File: tb/dram_test_seq_tb.sv
module dram_test_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0] iter = '0;
    logic [1:0] last = '0;
    logic [8:0] waitc = '0;
    logic stop = 1'b0, err = 1'b0, abrt = 1'b0;
    logic [3:0][2:0] b_cmd;
    logic [3:0][3:0] b_cke, b_odt, b_cs;
    logic [3:0]      b_mode;
    logic [3:0][1:0] b_rank, b_dir;
    logic [3:0][8:0] b_reps, b_idle;
    logic [3:0][4:0] b_gap;

    logic cmd_valid, ras_n, cas_n, we_n, trig;
    logic [3:0] cke, odt, cs_n;
    logic [1:0] dir, slot;
    logic [4:0] status;

    dram_test_seq u_dut (
        .clk(clk), .rst_n(rst_n), .iter_i(iter), .last_slot_i(last), .wait_i(waitc),
        .stop_on_err_i(stop), .err_i(err), .abort_i(abrt), .slot_cmd_i(b_cmd),
        .slot_cke_i(b_cke), .slot_odt_i(b_odt), .slot_cs_i(b_cs), .slot_csmode_i(b_mode),
        .slot_rank_i(b_rank), .slot_reps_i(b_reps), .slot_gap_i(b_gap),
        .slot_idle_i(b_idle), .slot_dir_i(b_dir), .cmd_valid_o(cmd_valid),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .cke_o(cke), .odt_o(odt),
        .cs_n_o(cs_n), .dir_o(dir), .slot_o(slot), .status_o(status), .trig_o(trig)
    );

    int total = 0, bad = 0;
    int cmd_cnt = 0, busy_cnt = 0, trig_cnt = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 command, 2 gap, 3 post-slot idle, 4 pass wait
    int m_ph, m_slot, m_left, m_cnt, m_iters;
    bit m_zero, m_done, m_err, m_pan, m_seen, m_trig;

    function automatic int eff(input int r);
        return (r == 0) ? 1 : r;
    endfunction

    task automatic m_first();
        m_ph = 1; m_slot = 0; m_left = eff(int'(b_reps[0]));
    endtask

    task automatic m_pass_end();
        if (m_iters == 255) m_first();
        else if (m_iters == 1) begin m_ph = 0; m_done = 1; end
        else begin m_iters--; m_first(); end
    endtask

    task automatic m_next();
        if (m_slot == int'(last)) begin
            if (waitc != 0) begin m_ph = 4; m_cnt = int'(waitc); end
            else m_pass_end();
        end else begin
            m_slot++; m_left = eff(int'(b_reps[m_slot])); m_ph = 1;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_slot = 0; m_left = 0; m_cnt = 0; m_iters = 0;
            m_zero = 1; m_done = 0; m_err = 0; m_pan = 0; m_seen = 0; m_trig = 0;
        end else begin
            bit was_zero;
            was_zero = m_zero;
            m_zero = (iter == 0);
            m_trig = 0;
            if (m_ph == 0) begin
                if (iter != 0 && was_zero) begin
                    m_first(); m_iters = int'(iter);
                    m_done = 0; m_err = 0; m_pan = 0; m_seen = 0;
                end
            end else begin
                if (err && !m_seen) begin m_seen = 1; m_trig = 1; end
                if (abrt) begin m_ph = 0; m_pan = 1; end
                else if (err && stop) begin m_ph = 0; m_err = 1; end
                else if (iter == 0) begin m_ph = 0; m_done = 1; end
                else if (m_ph == 1) begin
                    if (m_left > 1) begin
                        m_left--;
                        if (b_gap[m_slot] != 0) begin m_ph = 2; m_cnt = int'(b_gap[m_slot]); end
                    end else if (b_idle[m_slot] != 0) begin
                        m_ph = 3; m_cnt = int'(b_idle[m_slot]);
                    end else m_next();
                end else if (m_cnt == 1) begin
                    if (m_ph == 2) m_ph = 1;
                    else if (m_ph == 3) m_next();
                    else m_pass_end();
                end else m_cnt--;
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit c, b;
            logic [3:0] ecs, ecke, eodt;
            logic [2:0] estb;
            c = (m_ph == 1);
            b = (m_ph != 0);
            for (int r = 0; r < 4; r++)
                ecs[r] = !c ? 1'b1 : (b_mode[m_slot] ? (b_cs[m_slot][r] & (int'(b_rank[m_slot]) != r))
                                                     : b_cs[m_slot][r]);
            estb = c ? b_cmd[m_slot] : 3'b111;
            ecke = b ? b_cke[m_slot] : 4'h0;
            eodt = b ? b_odt[m_slot] : 4'h0;
            chk(cmd_valid == c && (!b || slot == 2'(m_slot)), "R2",
                int'({cmd_valid, slot}), int'({c, 2'(m_slot)}));
            chk({we_n, cas_n, ras_n} == estb && dir == (c ? b_dir[m_slot] : 2'b00), "R10",
                int'({we_n, cas_n, ras_n, dir}), int'({estb, (c ? b_dir[m_slot] : 2'b00)}));
            chk(cs_n == ecs, "R10", int'(cs_n), int'(ecs));
            chk(status == {m_pan, m_err, m_done, b, !b}, "R11",
                int'(status), int'({m_pan, m_err, m_done, b, !b}));
            chk(trig == m_trig, "R9", int'(trig), int'(m_trig));
            chk(cke == ecke && odt == eodt, "R12", int'({cke, odt}), int'({ecke, eodt}));
            cmd_cnt  += int'(cmd_valid);
            busy_cnt += int'(status[1]);
            trig_cnt += int'(trig);
        end
    end

    task automatic clr_cnt();
        cmd_cnt = 0; busy_cnt = 0; trig_cnt = 0;
    endtask

    task automatic wait_idle(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (status[0]) break;
        end
    endtask

    task automatic cfg_a();
        last = 2'd1; waitc = 9'd3;
        b_reps[0] = 9'd3; b_gap[0] = 5'd2; b_idle[0] = 9'd1;
        b_reps[1] = 9'd0; b_gap[1] = 5'd0; b_idle[1] = 9'd0;
    endtask

    task automatic cfg_b();
        last = 2'd3; waitc = 9'd0;
        b_reps = {9'd1, 9'd0, 9'd2, 9'd1};
        b_gap  = '0;
        b_idle = {9'd1, 9'd0, 9'd2, 9'd0};
    endtask

    initial begin
        b_cmd  = {3'b011, 3'b101, 3'b110, 3'b000};
        b_cke  = {4'hF, 4'h3, 4'h5, 4'hA};
        b_odt  = {4'h1, 4'h2, 4'h4, 4'h8};
        b_cs   = {4'hF, 4'h5, 4'hF, 4'hE};
        b_mode = 4'b1101;
        b_rank = {2'd3, 2'd2, 2'd1, 2'd0};
        b_dir  = {2'd3, 2'd2, 2'd1, 2'd0};
        b_reps = '0; b_gap = '0; b_idle = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(status == 5'b00001 && !cmd_valid && cs_n == 4'hF && cke == 4'h0, "R11",
            int'({status, cs_n}), int'({5'b00001, 4'hF}));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5: nested counts, two passes
        cfg_a(); clr_cnt();
        iter = 8'd2;
        wait_idle(200);
        chk(cmd_cnt == 8, "R3", cmd_cnt, 8);
        chk(busy_cnt == 24, "R5", busy_cnt, 24);
        chk(status == 5'b00101, "R5", int'(status), 5'b00101);
        // R1: no restart while field stays non-zero
        clr_cnt();
        repeat (10) @(negedge clk);
        chk(busy_cnt == 0, "R1", busy_cnt, 0);
        iter = 8'd0;
        @(negedge clk);

        // R2 R4 R10: four slots, rank decode, single pass
        cfg_b(); clr_cnt();
        iter = 8'd1;
        wait_idle(200);
        chk(cmd_cnt == 5 && busy_cnt == 8, "R4", cmd_cnt * 100 + busy_cnt, 508);
        iter = 8'd0;
        @(negedge clk);

        // R6: infinite mode ended by clearing the field
        clr_cnt();
        iter = 8'hFF;
        repeat (60) @(negedge clk);
        chk(status[1] && cmd_cnt > 20, "R6", cmd_cnt, 21);
        iter = 8'd0;
        @(negedge clk);
        chk(status == 5'b00101, "R6", int'(status), 5'b00101);

        // R7 R9: stop on error
        cfg_a(); clr_cnt();
        stop = 1'b1; iter = 8'd3;
        repeat (7) @(negedge clk);
        err = 1'b1;
        @(negedge clk);
        err = 1'b0;
        chk(status == 5'b01001, "R7", int'(status), 5'b01001);
        chk(trig_cnt == 1, "R9", trig_cnt, 1);
        stop = 1'b0; iter = 8'd0;
        @(negedge clk);

        // R7 R9: errors without stop, single trigger, run completes
        clr_cnt();
        iter = 8'd1;
        repeat (3) @(negedge clk);
        err = 1'b1; @(negedge clk); err = 1'b0;
        repeat (2) @(negedge clk);
        err = 1'b1; @(negedge clk); err = 1'b0;
        wait_idle(200);
        chk(status == 5'b00101 && cmd_cnt == 4, "R7", int'(status), 5'b00101);
        chk(trig_cnt == 1, "R9", trig_cnt, 1);
        iter = 8'd0;
        @(negedge clk);

        // R8: abort beats error stop
        clr_cnt();
        iter = 8'd2;
        repeat (5) @(negedge clk);
        abrt = 1'b1; err = 1'b1; stop = 1'b1;
        @(negedge clk);
        abrt = 1'b0; err = 1'b0; stop = 1'b0;
        chk(status == 5'b10001, "R8", int'(status), 5'b10001);
        iter = 8'd0;
        repeat (3) @(negedge clk);

        // R1: restart after clear, first command is slot 0
        cfg_b(); clr_cnt();
        iter = 8'd1;
        @(negedge clk);
        chk(cmd_valid && slot == 2'd0, "R1", int'({cmd_valid, slot}), 4);
        wait_idle(200);
        iter = 8'd0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule